// File: doc/BRIEF.md
# Operand Shifter with Carry-Out

This block is the combinational operand shifter of a load/store RISC execution stage. It takes a 32-bit operand, a 2-bit shift kind, a mode bit and two amount inputs: a 5-bit amount from the instruction and an 8-bit amount from a register. It returns the shifted operand and the carry the shifter produces. The flag register that holds the carry, the instruction decoder that drives the inputs, and the ALU that uses the result all live outside this block.

The two amount sources differ at their edges. With the instruction amount, a zero has a special meaning for the right shifts and the rotate. With the register amount, only the low 8 bits count, zero means "no shift", and amounts of 32 or more saturate.

The block has no clock and no state. A small control module decodes the special cases into a result select and a carry select. A datapath module performs the shift and the two muxes.

Top module: `barrel_shifter`

## Requirements
- R1: The shift kind encoding is 0 for logical left, 1 for logical right, 2 for arithmetic right (sign fill from bit 31) and 3 for rotate right. For an effective amount n from 1 to 31, the result is the operand shifted or rotated by n.
- R2: For an effective amount n from 1 to 31, the carry-out is the last bit moved out: operand bit 32-n for a left shift, and bit n-1 for right shifts and rotates.
- R3: With regMode=0, a logical left shift with immAmt=0 returns the operand unchanged and carryOut equals carryIn.
- R4: With regMode=0, a logical right shift with immAmt=0 acts as a shift by 32: the result is 0 and carryOut is operand bit 31.
- R5: With regMode=0, an arithmetic right shift with immAmt=0 acts as a shift by 32: every result bit equals operand bit 31, and carryOut is operand bit 31.
- R6: With regMode=0, a rotate with immAmt=0 rotates right by one through the carry: the result is {carryIn, operand[31:1]} and carryOut is operand bit 0.
- R7: With regMode=1 and regAmt=0, every shift kind returns the operand unchanged and carryOut equals carryIn.
- R8: With regMode=1, logical left or logical right by 32 or more gives 0. At exactly 32 the carry is operand bit 0 for left and bit 31 for right. Above 32 the carry is 0.
- R9: With regMode=1, arithmetic right by 32 or more fills the result with operand bit 31, and carryOut is operand bit 31.
- R10: With regMode=1, a rotate uses regAmt modulo 32. A nonzero regAmt that is a multiple of 32 returns the operand unchanged with carryOut equal to operand bit 31.
- R11: regMode=1 selects regAmt and ignores immAmt. regMode=0 selects immAmt and ignores regAmt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opIn | input | 32 | Operand to shift |
| shType | input | 2 | Shift kind (0 LSL, 1 LSR, 2 ASR, 3 ROR) |
| regMode | input | 1 | 1 selects regAmt, 0 selects immAmt |
| immAmt | input | 5 | Amount from the instruction |
| regAmt | input | 8 | Low byte of the register amount |
| carryIn | input | 1 | Current carry flag |
| result | output | 32 | Shifted operand |
| carryOut | output | 1 | Shifter carry-out |

## Verification
Directed cases use an operand with bit 31 set, bit 0 clear and a mixed middle. This lets a sign fill be told apart from a zero fill, and a carry from bit 0 be told apart from one from bit 31. Each zero-amount encoding is applied with carryIn at both values, so a rotate through the carry is separated from a plain pass-through. Register amounts of 31, 32, 33, 64 and 255 separate the last in-range shift, the exact-32 carry rule, saturation and the rotate modulo. Random operands then pair each mode with an independent random value on the unused amount input, which shows that the unused amount has no effect.

// File: rtl/shifter_pkg.sv
package shifter_pkg;
  typedef enum logic [1:0] {
    SH_LSL = 2'd0,
    SH_LSR = 2'd1,
    SH_ASR = 2'd2,
    SH_ROR = 2'd3
  } shKind_e;

  typedef enum logic [2:0] {
    RES_PASS, RES_ZERO, RES_FILL, RES_RRX, RES_SHIFT
  } resSel_e;

  typedef enum logic [2:0] {
    CY_IN, CY_MSB, CY_LSB, CY_LAST, CY_ZERO
  } cySel_e;

  typedef struct packed {
    resSel_e resSel;
    cySel_e  cySel;
  } shCtl_t;
endpackage

// File: rtl/shift_ctl.sv
module shift_ctl
  import shifter_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int REG_W = 8,
  localparam int IMM_W = $clog2(WIDTH)
) (
  input  shKind_e          kind,
  input  logic             regMode,
  input  logic [IMM_W-1:0] immAmt,
  input  logic [REG_W-1:0] regAmt,
  output shCtl_t           ctl,
  output logic [IMM_W-1:0] amt
);
  localparam logic [REG_W-1:0] FULL = REG_W'(WIDTH);

  always_comb begin
    ctl.resSel = RES_SHIFT;
    ctl.cySel  = CY_LAST;
    amt        = immAmt;
    if (!regMode) begin
      if (immAmt == '0) begin
        unique case (kind)
          SH_LSL: begin ctl.resSel = RES_PASS; ctl.cySel = CY_IN;  end
          SH_LSR: begin ctl.resSel = RES_ZERO; ctl.cySel = CY_MSB; end
          SH_ASR: begin ctl.resSel = RES_FILL; ctl.cySel = CY_MSB; end
          SH_ROR: begin ctl.resSel = RES_RRX;  ctl.cySel = CY_LSB; end
          default: ;
        endcase
      end
    end else begin
      amt = regAmt[IMM_W-1:0];
      if (regAmt == '0) begin
        ctl.resSel = RES_PASS;
        ctl.cySel  = CY_IN;
      end else begin
        unique case (kind)
          SH_LSL, SH_LSR: begin
            if (regAmt == FULL) begin
              ctl.resSel = RES_ZERO;
              ctl.cySel  = (kind == SH_LSL) ? CY_LSB : CY_MSB;
            end else if (regAmt > FULL) begin
              ctl.resSel = RES_ZERO;
              ctl.cySel  = CY_ZERO;
            end
          end
          SH_ASR: begin
            if (regAmt >= FULL) begin
              ctl.resSel = RES_FILL;
              ctl.cySel  = CY_MSB;
            end
          end
          SH_ROR: begin
            if (regAmt[IMM_W-1:0] == '0) begin
              ctl.resSel = RES_PASS;
              ctl.cySel  = CY_MSB;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/shift_dp.sv
module shift_dp
  import shifter_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int IMM_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] opIn,
  input  shKind_e          kind,
  input  logic [IMM_W-1:0] amt,
  input  shCtl_t           ctl,
  input  logic             carryIn,
  output logic [WIDTH-1:0] result,
  output logic             carryOut
);
  logic [WIDTH-1:0] shifted;
  logic [WIDTH:0]   leftExt;
  logic [WIDTH:0]   rightExt;
  logic             lastOut;

  always_comb begin
    leftExt  = {1'b0, opIn} << amt;
    rightExt = {opIn, 1'b0} >> amt;
    unique case (kind)
      SH_LSL:  shifted = opIn << amt;
      SH_LSR:  shifted = opIn >> amt;
      SH_ASR:  shifted = WIDTH'($signed(opIn) >>> amt);
      default: shifted = (opIn >> amt) | (opIn << (WIDTH - int'(amt)));
    endcase
    lastOut = (kind == SH_LSL) ? leftExt[WIDTH] : rightExt[0];
  end

  always_comb begin
    unique case (ctl.resSel)
      RES_PASS: result = opIn;
      RES_ZERO: result = '0;
      RES_FILL: result = {WIDTH{opIn[WIDTH-1]}};
      RES_RRX:  result = {carryIn, opIn[WIDTH-1:1]};
      default:  result = shifted;
    endcase
    unique case (ctl.cySel)
      CY_IN:   carryOut = carryIn;
      CY_MSB:  carryOut = opIn[WIDTH-1];
      CY_LSB:  carryOut = opIn[0];
      CY_ZERO: carryOut = 1'b0;
      default: carryOut = lastOut;
    endcase
  end
endmodule

// File: rtl/barrel_shifter.sv
module barrel_shifter
  import shifter_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int REG_W = 8,
  localparam int IMM_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] opIn,
  input  logic [1:0]       shType,
  input  logic             regMode,
  input  logic [IMM_W-1:0] immAmt,
  input  logic [REG_W-1:0] regAmt,
  input  logic             carryIn,
  output logic [WIDTH-1:0] result,
  output logic             carryOut
);
  shKind_e          kind;
  shCtl_t           ctl;
  logic [IMM_W-1:0] amt;

  assign kind = shKind_e'(shType);

  shift_ctl #(.WIDTH(WIDTH), .REG_W(REG_W)) u_ctl (
    .kind(kind), .regMode(regMode), .immAmt(immAmt),
    .regAmt(regAmt), .ctl(ctl), .amt(amt)
  );

  shift_dp #(.WIDTH(WIDTH)) u_dp (
    .opIn(opIn), .kind(kind), .amt(amt), .ctl(ctl),
    .carryIn(carryIn), .result(result), .carryOut(carryOut)
  );
endmodule

// File: rtl/shifter_chk.sv
module shifter_chk #(
  parameter int WIDTH = 32,
  parameter int REG_W = 8,
  localparam int IMM_W = $clog2(WIDTH)
) (
  input logic [WIDTH-1:0] opIn,
  input logic [1:0]       shType,
  input logic             regMode,
  input logic [IMM_W-1:0] immAmt,
  input logic [REG_W-1:0] regAmt,
  input logic             carryIn,
  input logic [WIDTH-1:0] result,
  input logic             carryOut
);
  localparam logic [REG_W-1:0] FULL = REG_W'(WIDTH);

  always_comb begin
    if (!regMode && immAmt == '0) begin
      // R3
      if (shType == 2'd0) imm_lsl_zero_chk: assert (result == opIn && carryOut == carryIn);
      // R4
      if (shType == 2'd1) imm_lsr_zero_chk: assert (result == '0 && carryOut == opIn[WIDTH-1]);
      // R6
      if (shType == 2'd3) imm_rrx_chk: assert (result == {carryIn, opIn[WIDTH-1:1]} && carryOut == opIn[0]);
    end
    if (regMode) begin
      // R7
      if (regAmt == '0) reg_zero_pass_chk: assert (result == opIn && carryOut == carryIn);
      // R8
      if (regAmt > FULL && shType[1] == 1'b0) reg_over_clear_chk: assert (result == '0 && !carryOut);
      // R9
      if (regAmt >= FULL && shType == 2'd2) reg_asr_fill_chk: assert (result == {WIDTH{opIn[WIDTH-1]}} && carryOut == opIn[WIDTH-1]);
    end
  end
endmodule

bind barrel_shifter shifter_chk #(.WIDTH(WIDTH), .REG_W(REG_W)) u_chk (.*);

// File: tb/sim_barrel_shifter.sv
module sim_barrel_shifter;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [31:0] opIn;
  logic [1:0]  shType;
  logic        regMode;
  logic [4:0]  immAmt;
  logic [7:0]  regAmt;
  logic        carryIn;
  logic [31:0] result;
  logic        carryOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  barrel_shifter u0 (.*);

  function automatic logic [32:0] plainShift(logic [31:0] x, logic [1:0] t, int n);
    logic [63:0] w;
    logic signed [63:0] s;
    case (t)
      2'd0: begin w = {32'b0, x} << n; return {w[32], w[31:0]}; end
      2'd1: begin w = {x, 32'b0} >> n; return {w[31], w[63:32]}; end
      2'd2: begin s = $signed({x, 32'b0}) >>> n; return {s[31], s[63:32]}; end
      default: begin w = {x, x} >> n; return {w[31], w[31:0]}; end
    endcase
  endfunction

  function automatic logic [32:0] model(logic [31:0] x, logic [1:0] t, logic m,
                                        logic [4:0] ia, logic [7:0] ra, logic c);
    if (!m) begin
      if (ia != 0) return plainShift(x, t, int'(ia));
      case (t)
        2'd0: return {c, x};
        2'd1: return {x[31], 32'b0};
        2'd2: return {x[31], {32{x[31]}}};
        default: return {x[0], c, x[31:1]};
      endcase
    end
    if (ra == 0) return {c, x};
    case (t)
      2'd0: return (ra < 32) ? plainShift(x, t, int'(ra)) : (ra == 32) ? {x[0], 32'b0} : 33'b0;
      2'd1: return (ra < 32) ? plainShift(x, t, int'(ra)) : (ra == 32) ? {x[31], 32'b0} : 33'b0;
      2'd2: return (ra < 32) ? plainShift(x, t, int'(ra)) : {x[31], {32{x[31]}}};
      default: return (ra % 32 == 0) ? {x[31], x} : plainShift(x, t, int'(ra % 32));
    endcase
  endfunction

  function automatic string classify(logic [1:0] t, logic m, logic [4:0] ia, logic [7:0] ra);
    if (!m) begin
      if (ia != 0) return "R2";
      return (t == 0) ? "R3" : (t == 1) ? "R4" : (t == 2) ? "R5" : "R6";
    end
    if (ra == 0) return "R7";
    if (t == 3) return "R10";
    if (ra >= 32) return (t == 2) ? "R9" : "R8";
    return "R11";
  endfunction

  task automatic check(logic [31:0] x, logic [1:0] t, logic m, logic [4:0] ia,
                       logic [7:0] ra, logic c, string tag);
    logic [32:0] exp;
    @(negedge clk);
    opIn = x; shType = t; regMode = m; immAmt = ia; regAmt = ra; carryIn = c;
    #1;
    exp = model(x, t, m, ia, ra, c);
    nChecks++;
    if ({carryOut, result} !== exp) begin
      nFails++;
      $display("FAIL %s: t=%0d m=%0b ia=%0d ra=%0d c=%0b x=%h got c=%0b r=%h exp c=%0b r=%h",
               tag, t, m, ia, ra, c, x, carryOut, result, exp[32], exp[31:0]);
    end
  endtask

  initial begin
    #800000;
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    logic [31:0] pat;
    pat = 32'hA5C3_0F12;
    void'($urandom(32'd20250611));
    // reset-state style idle check: register amount 0 passes through (R7)
    check(pat, 2'd0, 1'b1, 5'd0, 8'd0, 1'b0, "R7");
    // R1 R2 each kind at representative amounts
    for (int t = 0; t < 4; t++) begin
      check(pat, 2'(t), 1'b0, 5'd1, 8'd200, 1'b0, "R1");
      check(pat, 2'(t), 1'b0, 5'd13, 8'd0, 1'b1, "R1");
      check(pat, 2'(t), 1'b0, 5'd31, 8'd7, 1'b0, "R2");
    end
    // R3..R6 with carryIn both ways
    for (int c = 0; c < 2; c++) begin
      check(pat, 2'd0, 1'b0, 5'd0, 8'd9, 1'(c), "R3");
      check(pat, 2'd1, 1'b0, 5'd0, 8'd9, 1'(c), "R4");
      check(pat, 2'd2, 1'b0, 5'd0, 8'd9, 1'(c), "R5");
      check(32'h7F00_0001, 2'd2, 1'b0, 5'd0, 8'd9, 1'(c), "R5");
      check(pat, 2'd3, 1'b0, 5'd0, 8'd9, 1'(c), "R6");
    end
    // R7 each kind with carryIn 1
    for (int t = 0; t < 4; t++) check(pat, 2'(t), 1'b1, 5'd17, 8'd0, 1'b1, "R7");
    // R8 R9 R10 boundaries
    for (int t = 0; t < 4; t++) begin
      check(pat, 2'(t), 1'b1, 5'd0, 8'd31, 1'b1, "R11");
      check(32'h8000_0001, 2'(t), 1'b1, 5'd0, 8'd32, 1'b0, (t == 3) ? "R10" : (t == 2) ? "R9" : "R8");
      check(32'hFFFF_FFFF, 2'(t), 1'b1, 5'd0, 8'd33, 1'b1, (t == 3) ? "R10" : (t == 2) ? "R9" : "R8");
      check(pat, 2'(t), 1'b1, 5'd3, 8'd64, 1'b0, (t == 3) ? "R10" : (t == 2) ? "R9" : "R8");
      check(pat, 2'(t), 1'b1, 5'd3, 8'd255, 1'b0, (t == 3) ? "R10" : (t == 2) ? "R9" : "R8");
    end
    check(pat, 2'd3, 1'b1, 5'd0, 8'd37, 1'b0, "R10");
    // R11 unused amount ignored
    check(pat, 2'd1, 1'b1, 5'd0, 8'd4, 1'b0, "R11");
    check(pat, 2'd1, 1'b0, 5'd4, 8'd250, 1'b0, "R11");
    // random
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] x;
      logic [1:0]  t;
      logic        m;
      logic [4:0]  ia;
      logic [7:0]  ra;
      logic        c;
      x = $urandom; t = 2'($urandom); m = 1'($urandom); ia = 5'($urandom);
      c = 1'($urandom);
      case ($urandom % 8)
        0: ra = 8'd0;
        1: ra = 8'd32;
        2: ra = 8'(31 + $urandom % 3);
        3: ra = 8'(($urandom % 8) * 32);
        default: ra = 8'($urandom);
      endcase
      if ($urandom % 6 == 0) ia = 5'd0;
      check(x, t, m, ia, ra, c, classify(t, m, ia, ra));
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule